// File: doc/BRIEF.md
# Multi-rail power-up sequencer

This block orders the start-up of a controller that manages four supply rails: a core rail, a bus rail, a graphics rail and a chipset rail. Analog measurements are not made here. Comparator results arrive as single-bit flags, and each soft-start ramp is a saturating digital code that moves by `STEP` on every cycle in which the step tick is high. All thresholds are parameter codes on an 8-bit scale where 255 stands for full charge, about 4.5 V.

The first ramp starts once the bias, main and auxiliary supplies all report ready. It jumps to a starting code and then climbs at the slow rate. The bus rail is enabled while this ramp stays above a low threshold. The second ramp stays at zero until the bus rail leaves undervoltage, and the core and graphics rails follow it. Two status outputs report progress: a delayed bus-good flag and an overall power-good flag. A separate fault block can ask for a discharge. The first ramp then falls by one step per tick, the second ramp empties at once, and the rails shut down in turn.

The chipset rail does not wait for the supply-ready flags. Its reference is held at an intermediate code while the auxiliary supply is present, and it follows the first ramp once that ramp passes the intermediate code. Every flag input passes through a two-flop synchroniser. The step tick is already synchronous to the clock.

Top module: `pwr_seq`

## Requirements
- R1: The first ramp stays at 0 and the bus rail stays disabled unless all three supply-ready inputs (bias_ok_i, main_ok_i, aux_ok_i) are high. If any of them drops, the first ramp is cleared.
- R2: Once all supplies are ready, the first ramp jumps to JUMP_CODE (57) without waiting for a step. After that, each step adds STEP (4), and the ramp saturates at MAX_CODE (255). Without a step the ramp holds its value.
- R3: The second ramp is held at 0 until the synchronised bus undervoltage flag is low while the first ramp is running. After release, each step adds STEP, with saturation at MAX_CODE.
- R4: bus_good_o is low while bus undervoltage is set or while the second ramp is below VALLEY_CODE (71). Once both conditions clear, it rises on a high core_pulse_i and then stays high.
- R5: pwr_good_o is high exactly when core_win_i is high, bus_uv_i, agp_uv_i and chip_uv_i are all low, and the sequencer is running.
- R6: up_a_o and up_b_o are high exactly when the matching ramp is strictly above UP_CODE (227).
- R7: While discharge_i is high, the first ramp drops by STEP per step with a floor at 0, the second ramp and bus_good_o are cleared, and the core and graphics enables go low. The bus enable and the sequencer's running state fall only when the first ramp drops below LOW_CODE (45). When discharge_i is released with the first ramp below JUMP_CODE, the ramp jumps to JUMP_CODE again.
- R8: en_chip_o follows aux_ok_i regardless of the other supplies. chip_ref_o is 0 when the auxiliary supply is absent. When it is present, chip_ref_o is the larger of MID_CODE (85) and the first ramp.
- R9: hold_i clears the first ramp and disables rails 1 to 3 for as long as it is high.
- R10: en_bus_o is high while the sequencer is running. en_core_o and en_agp_o are high only while it is running and the second ramp is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bias_ok_i | input | 1 | Bias supply ready |
| main_ok_i | input | 1 | Main input supply ready |
| aux_ok_i | input | 1 | Auxiliary supply present |
| bus_uv_i | input | 1 | Bus rail below 90 % |
| core_win_i | input | 1 | Core rail inside ±10 % window |
| agp_uv_i | input | 1 | Graphics rail undervoltage |
| chip_uv_i | input | 1 | Chipset rail undervoltage |
| core_pulse_i | input | 1 | Core PWM has produced a pulse |
| discharge_i | input | 1 | Discharge request from the fault block |
| hold_i | input | 1 | External hold of the first ramp at zero |
| step_i | input | 1 | Synchronous ramp step tick |
| ramp_a_o | output | RAMP_W | First soft-start ramp code |
| ramp_b_o | output | RAMP_W | Second soft-start ramp code |
| up_a_o | output | 1 | First ramp above UP_CODE |
| up_b_o | output | 1 | Second ramp above UP_CODE |
| en_bus_o | output | 1 | Bus rail enable |
| en_core_o | output | 1 | Core rail enable |
| en_agp_o | output | 1 | Graphics rail enable |
| en_chip_o | output | 1 | Chipset rail enable |
| chip_ref_o | output | RAMP_W | Chipset rail reference code |
| bus_good_o | output | 1 | Delayed bus-good flag |
| pwr_good_o | output | 1 | System power-good flag |

## Verification
The assertions check several rules on every cycle:
- the second ramp is zero whenever it is not released;
- the ramp is released only after a cycle without bus undervoltage;
- bus-good never coexists with a second ramp below the valley code;
- power-good always follows a running cycle;
- a nonzero first ramp always follows ready supplies;
- a ramp never moves without a step and never rises during discharge.

Some behaviour only the bench's scenarios can show:
- the exact ramp codes along a full climb and a full descent;
- the jump value on restart;
- the threshold at which the bus rail drops;
- the complete truth table of power-good;
- the chipset reference tracking.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // index of each flag in the synchroniser bundle
  typedef enum int {
    F_BIAS  = 0,
    F_MAIN  = 1,
    F_AUX   = 2,
    F_BUSUV = 3,
    F_WIN   = 4,
    F_AGPUV = 5,
    F_CHPUV = 6,
    F_PULSE = 7,
    F_DIS   = 8,
    F_HOLD  = 9
  } flag_idx_e;
  localparam int N_FLAGS = 10;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b0;
        q_o[i]    <= 1'b0;
      end else begin
        meta_q[i] <= d_i[i];
        q_o[i]    <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
  parameter int W     = 8,
  parameter int STEP  = 4,
  parameter int FLOOR = 0,
  parameter int MAX   = 255
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         down_i,
  input  logic         release_i,
  input  logic         step_i,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] STEP_C = W'(STEP);
  localparam logic [W-1:0] MAX_C  = W'(MAX);
  localparam logic [W:0]   MAX_X  = (W+1)'(MAX);

  logic         below_floor;
  logic [W-1:0] floor_code;
  logic [W:0]   up_sum;
  logic [W-1:0] code_d;

  if (FLOOR > 0) begin : g_jump
    localparam logic [W-1:0] FLOOR_C = W'(FLOOR);
    assign below_floor = code_o < FLOOR_C;
    assign floor_code  = FLOOR_C;
  end else begin : g_nojump
    assign below_floor = 1'b0;
    assign floor_code  = '0;
  end

  always_comb begin
    up_sum = {1'b0, code_o} + {1'b0, STEP_C};
    code_d = code_o;
    if (clear_i) begin
      code_d = '0;
    end else if (down_i) begin
      if (step_i) code_d = (code_o < STEP_C) ? '0 : code_o - STEP_C;
    end else if (release_i) begin
      if (below_floor)  code_d = floor_code;
      else if (step_i)  code_d = (up_sum > MAX_X) ? MAX_C : up_sum[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= code_d;
  end

  // no movement without a tick once past the jump point
  assert_hold_no_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !down_i && release_i && !below_floor && !step_i) |=> $stable(code_o));

  assert_down_no_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_i && !clear_i) |=> (code_o <= $past(code_o)));
endmodule

// File: rtl/pwr_seq_status.sv
module pwr_seq_status #(
  parameter int W      = 8,
  parameter int VALLEY = 71
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         discharge_i,
  input  logic         bus_uv_i,
  input  logic         core_win_i,
  input  logic         agp_uv_i,
  input  logic         chip_uv_i,
  input  logic         core_pulse_i,
  input  logic [W-1:0] ramp_b_i,
  output logic         b_release_o,
  output logic         bus_good_o,
  output logic         pwr_good_o
);
  localparam logic [W-1:0] VALLEY_C = W'(VALLEY);

  logic stop;
  assign stop = !run_i || discharge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_release_o <= 1'b0;
      bus_good_o  <= 1'b0;
      pwr_good_o  <= 1'b0;
    end else begin
      if (stop)           b_release_o <= 1'b0;
      else if (!bus_uv_i) b_release_o <= 1'b1;

      if (stop || bus_uv_i || ramp_b_i < VALLEY_C) bus_good_o <= 1'b0;
      else if (core_pulse_i)                       bus_good_o <= 1'b1;

      pwr_good_o <= run_i && core_win_i && !bus_uv_i && !agp_uv_i && !chip_uv_i;
    end
  end

  assert_ramp_b_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_release_o |-> (ramp_b_i == '0));

  assert_release_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(b_release_o) |-> $past(!bus_uv_i));

  assert_bus_good_valley_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_good_o |-> (ramp_b_i >= VALLEY_C));

  assert_pg_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_o |-> $past(run_i));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int RAMP_W      = 8,
  parameter int STEP        = 4,
  parameter int JUMP_CODE   = 57,
  parameter int LOW_CODE    = 45,
  parameter int VALLEY_CODE = 71,
  parameter int UP_CODE     = 227,
  parameter int MAX_CODE    = 255,
  parameter int MID_CODE    = 85
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bias_ok_i,
  input  logic              main_ok_i,
  input  logic              aux_ok_i,
  input  logic              bus_uv_i,
  input  logic              core_win_i,
  input  logic              agp_uv_i,
  input  logic              chip_uv_i,
  input  logic              core_pulse_i,
  input  logic              discharge_i,
  input  logic              hold_i,
  input  logic              step_i,
  output logic [RAMP_W-1:0] ramp_a_o,
  output logic [RAMP_W-1:0] ramp_b_o,
  output logic              up_a_o,
  output logic              up_b_o,
  output logic              en_bus_o,
  output logic              en_core_o,
  output logic              en_agp_o,
  output logic              en_chip_o,
  output logic [RAMP_W-1:0] chip_ref_o,
  output logic              bus_good_o,
  output logic              pwr_good_o
);
  localparam logic [RAMP_W-1:0] LOW_C = RAMP_W'(LOW_CODE);
  localparam logic [RAMP_W-1:0] UP_C  = RAMP_W'(UP_CODE);
  localparam logic [RAMP_W-1:0] MID_C = RAMP_W'(MID_CODE);

  logic [N_FLAGS-1:0] raw, fl;
  logic supplies_ok, run, b_release;

  always_comb begin
    raw          = '0;
    raw[F_BIAS]  = bias_ok_i;
    raw[F_MAIN]  = main_ok_i;
    raw[F_AUX]   = aux_ok_i;
    raw[F_BUSUV] = bus_uv_i;
    raw[F_WIN]   = core_win_i;
    raw[F_AGPUV] = agp_uv_i;
    raw[F_CHPUV] = chip_uv_i;
    raw[F_PULSE] = core_pulse_i;
    raw[F_DIS]   = discharge_i;
    raw[F_HOLD]  = hold_i;
  end

  pwr_seq_sync #(.N(N_FLAGS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (fl)
  );

  assign supplies_ok = fl[F_BIAS] && fl[F_MAIN] && fl[F_AUX];
  assign run         = supplies_ok && !fl[F_HOLD] && (ramp_a_o >= LOW_C);

  pwr_seq_ramp #(.W(RAMP_W), .STEP(STEP), .FLOOR(JUMP_CODE), .MAX(MAX_CODE)) i_ramp_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!supplies_ok || fl[F_HOLD]),
    .down_i   (fl[F_DIS]),
    .release_i(1'b1),
    .step_i   (step_i),
    .code_o   (ramp_a_o)
  );

  pwr_seq_ramp #(.W(RAMP_W), .STEP(STEP), .FLOOR(0), .MAX(MAX_CODE)) i_ramp_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!run || fl[F_DIS]),
    .down_i   (1'b0),
    .release_i(b_release),
    .step_i   (step_i),
    .code_o   (ramp_b_o)
  );

  pwr_seq_status #(.W(RAMP_W), .VALLEY(VALLEY_CODE)) i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .discharge_i (fl[F_DIS]),
    .bus_uv_i    (fl[F_BUSUV]),
    .core_win_i  (fl[F_WIN]),
    .agp_uv_i    (fl[F_AGPUV]),
    .chip_uv_i   (fl[F_CHPUV]),
    .core_pulse_i(fl[F_PULSE]),
    .ramp_b_i    (ramp_b_o),
    .b_release_o (b_release),
    .bus_good_o  (bus_good_o),
    .pwr_good_o  (pwr_good_o)
  );

  assign up_a_o     = ramp_a_o > UP_C;
  assign up_b_o     = ramp_b_o > UP_C;
  assign en_bus_o   = run;
  assign en_core_o  = run && b_release;
  assign en_agp_o   = run && b_release;
  assign en_chip_o  = fl[F_AUX];
  assign chip_ref_o = !fl[F_AUX] ? '0 : ((ramp_a_o > MID_C) ? ramp_a_o : MID_C);

  assert_ramp_needs_supply_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_a_o != '0) |-> $past(supplies_ok));
endmodule

// File: tb/test_pwr_seq.sv
module test_pwr_seq;
  localparam int STEP = 4, JUMP = 57, LOW = 45, VALLEY = 71, UP = 227, MAX = 255, MID = 85;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_ok = 0, main_ok = 0, aux_ok = 0, bus_uv = 1, core_win = 0, agp_uv = 1;
  logic chip_uv = 1, core_pulse = 0, discharge = 0, hold = 0, step = 0;
  logic [7:0] ramp_a, ramp_b, chip_ref;
  logic up_a, up_b, en_bus, en_core, en_agp, en_chip, bus_good, pwr_good;
  int checks = 0, errors = 0;
  int exp_a = 0, exp_b = 0;

  always #4 clk = ~clk;

  pwr_seq i_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .bias_ok_i(bias_ok), .main_ok_i(main_ok), .aux_ok_i(aux_ok),
    .bus_uv_i(bus_uv), .core_win_i(core_win), .agp_uv_i(agp_uv), .chip_uv_i(chip_uv),
    .core_pulse_i(core_pulse), .discharge_i(discharge), .hold_i(hold), .step_i(step),
    .ramp_a_o(ramp_a), .ramp_b_o(ramp_b), .up_a_o(up_a), .up_b_o(up_b), .en_bus_o(en_bus),
    .en_core_o(en_core), .en_agp_o(en_agp), .en_chip_o(en_chip), .chip_ref_o(chip_ref),
    .bus_good_o(bus_good), .pwr_good_o(pwr_good)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
    cyc(2);
  endtask

  function automatic int ref_of(input int a);
    return (a > MID) ? a : MID;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    cyc(4);
    chk("reset ramp_a", ramp_a, 0);
    chk("reset ramp_b", ramp_b, 0);
    chk("reset enables", {en_bus, en_core, en_agp, en_chip}, 0);
    chk("reset status", {bus_good, pwr_good, up_a, up_b}, 0);
    rst_n = 1'b1;
    cyc(3);

    // R1 / R8: every partial supply combination
    for (int m = 0; m < 7; m++) begin
      {aux_ok, main_ok, bias_ok} = 3'(m);
      cyc(5);
      tick(); tick();
      chk("R1 ramp_a idle", ramp_a, 0);
      chk("R1 en_bus idle", en_bus, 0);
      chk("R8 en_chip", en_chip, int'(aux_ok));
      chk("R8 chip_ref", chip_ref, aux_ok ? MID : 0);
    end

    {aux_ok, main_ok, bias_ok} = 3'b111;
    cyc(6);
    exp_a = JUMP;
    chk("R2 jump", ramp_a, exp_a);
    chk("R10 en_bus", en_bus, 1);
    chk("R10 en_core before release", en_core, 0);
    cyc(5);
    chk("R2 hold w/o step", ramp_a, exp_a);

    // R3: second ramp stays at zero while bus is under
    for (int k = 0; k < 5; k++) begin
      tick();
      exp_a = (exp_a + STEP > MAX) ? MAX : exp_a + STEP;
      chk("R2 ramp_a step", ramp_a, exp_a);
      chk("R3 ramp_b held", ramp_b, 0);
      chk("R8 chip_ref", chip_ref, ref_of(exp_a));
    end

    bus_uv = 1'b0;
    cyc(6);
    chk("R10 en_core released", en_core, 1);
    chk("R10 en_agp released", en_agp, 1);
    core_pulse = 1'b1;
    cyc(6);
    chk("R4 bus_good below valley", bus_good, 0);

    for (int k = 0; k < 70; k++) begin
      tick();
      exp_a = (exp_a + STEP > MAX) ? MAX : exp_a + STEP;
      exp_b = (exp_b + STEP > MAX) ? MAX : exp_b + STEP;
      chk("R2 ramp_a climb", ramp_a, exp_a);
      chk("R3 ramp_b climb", ramp_b, exp_b);
      chk("R6 up_a", up_a, int'(exp_a > UP));
      chk("R6 up_b", up_b, int'(exp_b > UP));
      chk("R4 bus_good", bus_good, int'(exp_b >= VALLEY));
      chk("R8 chip_ref", chip_ref, ref_of(exp_a));
    end

    // R5 / R4: every status-flag combination
    for (int v = 0; v < 16; v++) begin
      core_win = v[0]; agp_uv = v[1]; chip_uv = v[2]; bus_uv = v[3];
      cyc(5);
      chk("R5 pwr_good", pwr_good, int'(v[0] && !v[1] && !v[2] && !v[3]));
      chk("R4 bus_good vs uv", bus_good, int'(!v[3]));
    end
    core_win = 1; agp_uv = 0; chip_uv = 0; bus_uv = 0;
    cyc(5);
    chk("R5 pwr_good all ok", pwr_good, 1);

    // R7: discharge
    discharge = 1'b1;
    cyc(5);
    chk("R7 ramp_b cleared", ramp_b, 0);
    chk("R7 bus_good cleared", bus_good, 0);
    chk("R7 en_core off", en_core, 0);
    chk("R7 en_bus still on", en_bus, 1);
    chk("R7 ramp_a no step", ramp_a, exp_a);
    for (int k = 0; k < 66; k++) begin
      tick();
      exp_a = (exp_a < STEP) ? 0 : exp_a - STEP;
      chk("R7 ramp_a descent", ramp_a, exp_a);
      chk("R7 en_bus vs low", en_bus, int'(exp_a >= LOW));
      chk("R5 pwr_good vs low", pwr_good, int'(exp_a >= LOW));
      chk("R6 up_a descent", up_a, int'(exp_a > UP));
    end
    discharge = 1'b0;
    cyc(6);
    exp_a = JUMP;
    chk("R7 rejump", ramp_a, exp_a);
    chk("R7 en_bus back", en_bus, 1);
    chk("R10 en_core back", en_core, 1);
    chk("R3 ramp_b restart", ramp_b, 0);

    // R9: hold
    hold = 1'b1;
    cyc(5);
    chk("R9 ramp_a held", ramp_a, 0);
    chk("R9 rails off", {en_bus, en_core, en_agp}, 0);
    chk("R9 pwr_good", pwr_good, 0);
    tick();
    chk("R9 no climb", ramp_a, 0);
    hold = 1'b0;
    cyc(6);
    chk("R9 release jump", ramp_a, JUMP);

    // R1 / R8: supply loss
    bias_ok = 1'b0;
    cyc(5);
    chk("R1 ramp_a cleared", ramp_a, 0);
    chk("R1 en_bus off", en_bus, 0);
    chk("R8 chip stays", en_chip, 1);
    chk("R8 chip_ref mid", chip_ref, MID);
    aux_ok = 1'b0;
    cyc(5);
    chk("R8 chip off", en_chip, 0);
    chk("R8 chip_ref zero", chip_ref, 0);

    summary();
  end
endmodule